// File: doc/BRIEF.md
# Dictionary Word Decoder

This block turns a compressed cache-line bitstream back into the original 32-bit words. The stream arrives in fixed-width beats, most significant bit first, under a valid/ready handshake. The decoder reads a 2-bit or 4-bit prefix for each word and from it decides how to build the word. Depending on the code, the word is all zero, carries literal bytes, or takes bytes from a small dictionary of recent words. Each decoded word leaves through a registered valid/ready port. The sixteenth word of a line carries a last flag.

The decoder keeps its own dictionary and updates it by the same rule the compressor follows, so every index in the stream points at the entry the compressor meant. Every compressed line starts on a beat boundary. Whatever bits are left between a line's final code and the end of its beat are padding and are thrown away. If a line contains a prefix that has no meaning, the decoder drops that line, pulses an error output and starts the next line at the following beat.

Top module: `dict_word_decoder`

## Requirements
- R1: Prefix `00` produces the word 0x00000000 and uses 2 bits.
- R2: Prefix `01` is followed by 32 literal bits, most significant first. The word is those 32 bits, and the code uses 34 bits in total.
- R3: Prefix `10` is followed by a 4-bit index. The word is the dictionary entry at that index, and the code uses 6 bits.
- R4: Prefix `1100` is followed by a 4-bit index and then 16 literal bits. The upper 16 bits of the word come from the indexed entry and the lower 16 bits are the literal. The code uses 24 bits.
- R5: Prefix `1101` is followed by 8 literal bits. The word is that byte in bits 7:0, with zeros above it. The code uses 12 bits.
- R6: The dictionary has 16 entries of 32 bits. All entries are cleared to zero at reset and whenever a line ends or is dropped. Each word decoded under `01` or `1100` is written at a write pointer, and the pointer then advances by one. The pointer starts at entry 0 for each line. Words decoded under the other codes leave the dictionary unchanged.
- R7: A line holds 16 words, and `outLast` is high with the 16th word. Bits after the 16th code, up to the end of that input beat, are discarded. The next line begins at the most significant bit of the next beat.
- R8: Prefixes `1110` and `1111` are illegal. On either one, `lineErr` is high for exactly one cycle and no word is emitted for that prefix. The dictionary is cleared, the rest of the current beat is discarded, and decoding resumes at the next beat as a new line.
- R9: While `outValid` is high and `outReady` is low, `outWord` and `outLast` hold and `outValid` stays high.
- R10: Input beats are 8 bits and consumed most significant bit first. `inReady` goes low when the buffer has no room for a whole beat, and no bit is lost or repeated across input or output stalls.
- R11: After reset, `outValid` and `lineErr` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Decoder can take a beat this cycle |
| inBits | input | 8 | Input beat, first stream bit in bit 7 |
| outValid | output | 1 | Decoded word present |
| outReady | input | 1 | Sink takes the word this cycle |
| outWord | output | 32 | Decoded word |
| outLast | output | 1 | Word is the 16th of its line |
| lineErr | output | 1 | One-cycle pulse on an illegal prefix |

## Verification
The hardest case to reach is a line ending while the first beat of the next line is already in the buffer. In that case the padding drop must stop exactly at the beat boundary and must not eat the new line's bits. A stalled output combined with continuous input builds up enough buffered bits to reach this state. The bench throttles `outReady` in an irregular pattern while beats arrive almost every cycle, so short-code lines end with a following beat already queued. Lines ending in an illegal prefix are followed at once by a line that reads dictionary index 0, which shows both the resumption point and the cleared dictionary.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

  typedef enum logic [2:0] {
    K_ZERO,
    K_LIT,
    K_FULL,
    K_PART,
    K_ZBYTE,
    K_BAD
  } codeKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // decode current code and emit its word
    logic endLine;  // take of the final word of a line
    logic abort;    // illegal prefix: drop the line
  } decStrobe_t;

endpackage

// File: rtl/wdec_ctrl.sv
module wdec_ctrl
  import wdec_pkg::*;
#(
  parameter int LINE_WORDS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       codeReady,
  input  logic       codeBad,
  input  logic       outReady,
  output decStrobe_t stb,
  output logic       outValid,
  output logic       outLast,
  output logic       lineErr
);

  localparam int WC_W = $clog2(LINE_WORDS);

  logic [WC_W-1:0] wordCnt;
  logic            canEmit;
  logic            lastNow;

  always_comb begin
    canEmit     = !outValid || outReady;
    lastNow     = (wordCnt == WC_W'(LINE_WORDS - 1));
    stb.take    = codeReady && !codeBad && canEmit;
    stb.abort   = codeReady && codeBad;
    stb.endLine = stb.take && lastNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt  <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      lineErr  <= 1'b0;
    end else begin
      lineErr <= stb.abort;
      if (stb.take) begin
        outValid <= 1'b1;
        outLast  <= lastNow;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (stb.abort || stb.endLine) wordCnt <= '0;
      else if (stb.take)            wordCnt <= wordCnt + WC_W'(1);
    end
  end

  AST_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (wordCnt == '0)); // R7

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    lineErr |-> (wordCnt == '0)); // R8

endmodule

// File: rtl/wdec_datapath.sv
module wdec_datapath
  import wdec_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int DICT_N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inBits,
  output logic             inReady,
  input  decStrobe_t       stb,
  output logic             codeReady,
  output logic             codeBad,
  output logic [31:0]      outWord
);

  localparam int IDX_W    = $clog2(DICT_N);
  localparam int LIT_LEN  = 34;
  localparam int FULL_LEN = 2 + IDX_W;
  localparam int PART_LEN = 4 + IDX_W + 16;
  localparam int ZB_LEN   = 12;
  localparam int BAD_LEN  = 4;
  localparam int BUF_W    = LIT_LEN + IN_W;
  localparam int CNT_W    = $clog2(BUF_W + 1);
  localparam int PH_W     = $clog2(IN_W);

  logic [BUF_W-1:0]   bitBuf;
  logic [CNT_W-1:0]   bitCnt;
  logic [PH_W-1:0]    phase;
  logic [31:0]        dict [DICT_N];
  logic [IDX_W-1:0]   wrPtr;

  logic [LIT_LEN-1:0] win;
  codeKind_t          kind;
  logic [CNT_W-1:0]   codeLen;
  logic [IDX_W-1:0]   idx;
  logic [31:0]        decWord;

  // prefix decode on the head of the buffer
  always_comb begin
    win     = bitBuf[BUF_W-1 -: LIT_LEN];
    kind    = K_ZERO;
    codeLen = CNT_W'(2);
    idx     = '0;
    decWord = '0;
    unique case (win[33:32])
      2'b00: ;
      2'b01: begin
        kind    = K_LIT;
        codeLen = CNT_W'(LIT_LEN);
        decWord = win[31:0];
      end
      2'b10: begin
        kind    = K_FULL;
        codeLen = CNT_W'(FULL_LEN);
        idx     = win[31 -: IDX_W];
        decWord = dict[idx];
      end
      default: begin
        unique case (win[31:30])
          2'b00: begin
            kind    = K_PART;
            codeLen = CNT_W'(PART_LEN);
            idx     = win[29 -: IDX_W];
            decWord = {dict[idx][31:16], win[29-IDX_W -: 16]};
          end
          2'b01: begin
            kind    = K_ZBYTE;
            codeLen = CNT_W'(ZB_LEN);
            decWord = {24'b0, win[29:22]};
          end
          default: begin
            kind    = K_BAD;
            codeLen = CNT_W'(BAD_LEN);
          end
        endcase
      end
    endcase
    codeBad   = (kind == K_BAD);
    codeReady = (bitCnt >= codeLen);
  end

  // consumption, padding drop and refill
  logic             closing;
  logic             accept;
  logic             pushNow;
  logic [PH_W-1:0]  phAfter;
  logic [PH_W-1:0]  pad;
  logic [CNT_W-1:0] dropLen;
  logic [CNT_W-1:0] cntAfter;
  logic [BUF_W-1:0] nextBuf;

  always_comb begin
    closing = stb.endLine || stb.abort;
    inReady = (bitCnt <= CNT_W'(BUF_W - IN_W));
    accept  = inValid && inReady;
    pushNow = stb.take && !stb.endLine && (kind == K_LIT || kind == K_PART);
    phAfter = phase + codeLen[PH_W-1:0];
    pad     = ~phAfter + PH_W'(1);
    if (stb.take || stb.abort)
      dropLen = codeLen + (closing ? CNT_W'(pad) : CNT_W'(0));
    else
      dropLen = '0;
    cntAfter = bitCnt - dropLen;
    nextBuf  = bitBuf << dropLen;
    if (accept)
      nextBuf = nextBuf | ({inBits, {(BUF_W-IN_W){1'b0}}} >> cntAfter);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitBuf  <= '0;
      bitCnt  <= '0;
      phase   <= '0;
      wrPtr   <= '0;
      outWord <= '0;
      for (int e = 0; e < DICT_N; e++) dict[e] <= '0;
    end else begin
      bitBuf <= nextBuf;
      bitCnt <= cntAfter + (accept ? CNT_W'(IN_W) : CNT_W'(0));
      if (closing)        phase <= '0;
      else if (stb.take)  phase <= phAfter;
      if (stb.take) outWord <= decWord;
      if (closing) begin
        wrPtr <= '0;
        for (int e = 0; e < DICT_N; e++) dict[e] <= '0;
      end else if (pushNow) begin
        dict[wrPtr] <= decWord;
        wrPtr       <= wrPtr + IDX_W'(1);
      end
    end
  end

  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BUF_W)); // R10

  AST_ACCEPT_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (bitCnt >= CNT_W'(IN_W))); // R10

endmodule

// File: rtl/dict_word_decoder.sv
module dict_word_decoder
  import wdec_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int DICT_N     = 16,
  parameter int LINE_WORDS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [IN_W-1:0] inBits,
  output logic            outValid,
  input  logic            outReady,
  output logic [31:0]     outWord,
  output logic            outLast,
  output logic            lineErr
);

  decStrobe_t stb;
  logic       codeReady;
  logic       codeBad;

  wdec_ctrl #(.LINE_WORDS(LINE_WORDS)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .codeReady (codeReady),
    .codeBad   (codeBad),
    .outReady  (outReady),
    .stb       (stb),
    .outValid  (outValid),
    .outLast   (outLast),
    .lineErr   (lineErr)
  );

  wdec_datapath #(.IN_W(IN_W), .DICT_N(DICT_N)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inBits    (inBits),
    .inReady   (inReady),
    .stb       (stb),
    .codeReady (codeReady),
    .codeBad   (codeBad),
    .outWord   (outWord)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord) && $stable(outLast))); // R9

endmodule

// File: tb/test_dict_word_decoder.sv
module test_dict_word_decoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [7:0]  inBits;
  logic        outValid;
  logic        outReady;
  logic [31:0] outWord;
  logic        outLast;
  logic        lineErr;

  always #5 clk = ~clk;

  dict_word_decoder i_dict_word_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inBits(inBits),
    .outValid(outValid), .outReady(outReady), .outWord(outWord), .outLast(outLast),
    .lineErr(lineErr)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0]  beats [0:4095];
  int          sLen = 0;
  logic [31:0] expW [0:1023];
  bit          expL [0:1023];
  int          expK [0:1023];
  int          nExp = 0;
  int          expErrs = 0;
  logic [31:0] refDict [0:15];
  int          refPtr, lineWords;
  logic [31:0] seed = 32'h1234_5678;

  int  got = 0, errSeen = 0, cyc = 0;
  bit  monOn = 0, sawStall = 0, holdPend = 0;
  logic [31:0] holdW;
  logic        holdL;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] nextRnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic string reqOf(input int k);
    case (k)
      0: return "R1";
      1: return "R2,R6";
      2: return "R3,R6";
      3: return "R4,R6";
      default: return "R5";
    endcase
  endfunction

  // ---------------- stream builder (reference model per R1..R8) -------------
  task automatic putBits(input logic [33:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      beats[sLen / 8][7 - (sLen % 8)] = v[i];
      sLen++;
    end
  endtask

  task automatic padBeat();
    while (sLen % 8 != 0) sLen++;
  endtask

  task automatic newLine();
    for (int e = 0; e < 16; e++) refDict[e] = '0;
    refPtr = 0;
    lineWords = 0;
  endtask

  task automatic encWord(input int kind, input int idx, input logic [31:0] lit);
    logic [31:0] w;
    bit push;
    push = 0;
    case (kind)
      0: begin putBits(34'd0, 2); w = '0; end
      1: begin putBits({2'b01, lit}, 34); w = lit; push = 1; end
      2: begin putBits({28'd0, 2'b10, idx[3:0]}, 6); w = refDict[idx]; end
      3: begin
        putBits({10'd0, 4'b1100, idx[3:0], lit[15:0]}, 24);
        w = {refDict[idx][31:16], lit[15:0]}; push = 1;
      end
      default: begin putBits({22'd0, 4'b1101, lit[7:0]}, 12); w = {24'd0, lit[7:0]}; end
    endcase
    if (push) begin
      refDict[refPtr] = w;
      refPtr = (refPtr + 1) % 16;
    end
    lineWords++;
    expW[nExp] = w;
    expK[nExp] = kind;
    expL[nExp] = (lineWords == 16);
    nExp++;
    if (lineWords == 16) begin
      padBeat();
      newLine();
    end
  endtask

  task automatic badPrefix(input logic [3:0] p);
    putBits({30'd0, p}, 4);
    padBeat();
    expErrs++;
    newLine();
  endtask

  task automatic buildStream();
    for (int b = 0; b < 4096; b++) beats[b] = '0;
    newLine();
    // full matches over indices 0..7 after eight literals
    for (int i = 0; i < 8; i++) encWord(1, 0, nextRnd());
    for (int i = 0; i < 8; i++) encWord(2, i, '0);
    // partial matches over indices 7..0
    for (int i = 0; i < 8; i++) encWord(1, 0, nextRnd());
    for (int i = 0; i < 8; i++) encWord(3, 7 - i, nextRnd());
    // full matches on the upper half, which should read as zero
    for (int i = 0; i < 8; i++) encWord(3, i, nextRnd());
    for (int i = 8; i < 16; i++) encWord(2, i, '0);
    // every byte value under the single-byte code
    for (int ln = 0; ln < 16; ln++)
      for (int i = 0; i < 16; i++) encWord(4, 0, 32'(ln * 16 + i));
    // all-zero line
    for (int i = 0; i < 16; i++) encWord(0, 0, '0);
    // illegal 1110 in the middle of a line
    for (int i = 0; i < 3; i++) encWord(1, 0, nextRnd());
    badPrefix(4'b1110);
    // new line must see a cleared dictionary
    encWord(2, 0, '0);
    encWord(2, 1, '0);
    for (int i = 0; i < 14; i++) encWord(int'(nextRnd() % 5), int'(nextRnd() % 16), nextRnd());
    // illegal 1111 as the first code
    badPrefix(4'b1111);
    encWord(3, 0, 32'h0000_BEEF);
    for (int i = 0; i < 15; i++) encWord(2, 0, '0);
    // random mix
    for (int ln = 0; ln < 20; ln++)
      for (int i = 0; i < 16; i++)
        encWord(int'(nextRnd() % 5), int'(nextRnd() % 16), nextRnd());
  endtask

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        outReady = !((cyc % 5) == 1 || (cyc % 11) == 4 || (cyc % 23) < 6);
        if (inValid && !inReady) sawStall = 1;
        if (lineErr) errSeen++;
        if (holdPend)
          check(outValid && outWord == holdW && outLast == holdL, "R9", outWord, holdW);
        holdPend = 0;
        if (outValid && !outReady) begin
          holdPend = 1; holdW = outWord; holdL = outLast;
        end
        if (outValid && outReady) begin
          if (got < nExp) begin
            check(outWord == expW[got], reqOf(expK[got]), outWord, expW[got]);
            check(outLast == expL[got], "R7", 32'(outLast), 32'(expL[got]));
          end else begin
            check(0, "R8 extra word", outWord, '0);
          end
          got++;
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d words", got, nExp);
      finishRun();
    end
  end

  // ---------------- main ----------------
  initial begin
    rstN = 0; inValid = 0; inBits = '0; outReady = 0;
    buildStream();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(outValid == 0, "R11 outValid", 32'(outValid), 0);
    check(lineErr == 0, "R11 lineErr", 32'(lineErr), 0);
    check(inReady == 1, "R11 inReady", 32'(inReady), 1);
    monOn = 1;
    for (int b = 0; b < sLen / 8; b++) begin
      if (b % 7 == 3) begin
        inValid = 0;
        @(negedge clk);
      end
      inValid = 1;
      inBits  = beats[b];
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 0;
    while (got < nExp) @(negedge clk);
    repeat (40) @(negedge clk);
    check(got == nExp, "R10 word count", 32'(got), 32'(nExp));
    check(sawStall, "R10 input stall seen", 32'(sawStall), 1);
    check(errSeen == expErrs, "R8 error pulses", 32'(errSeen), 32'(expErrs));
    finishRun();
  end

endmodule